// File: doc/BRIEF.md
# Threshold Adjustment Command Detector

This block sits beside a mode-0 SPI slave port and watches the serial clock, serial data and active-low chip select, together with a program-enable level that says the high programming voltage is present. It accepts a threshold adjustment only as a two-frame handshake. The first frame opens the request. The second frame commits it, and its final byte selects between raising the stored undervoltage threshold and returning it to its native low level.

All pins are brought into the system clock domain through a synchronizer chain. Each frame is then classified when chip select rises. A small sequencer walks the handshake. When the sequence is valid, the block emits a single-cycle pulse on one of two command outputs. It then holds a busy flag for the fixed write time, and after that keeps a recovery window in which every further request is ignored. Any wrong value, wrong bit count, short chip-select gap or loss of program-enable sends the sequencer back to idle.

Top module: `trip_prog_detect`

## Requirements
- R1: After reset, set_trip_o, reset_trip_o and busy_o are all low.
- R2: Data is sampled on rising serial-clock edges, MSB first. An opening frame of exactly 24 bits with value 0x030001, then chip select high for at least GAP_CYCLES, then a commit frame of 24 bits with value 0x020001, produces a one-cycle pulse on set_trip_o. The pulse is high SYNC_STAGES+1 clock edges after chip select rises at the end of the commit frame.
- R3: The same handshake with a commit value of 0x020003 produces a one-cycle pulse on reset_trip_o, with the same timing.
- R4: busy_o rises in the cycle of the command pulse and stays high for exactly WRITE_CYCLES cycles. busy_o never rises without a pulse.
- R5: No pulse is produced while busy_o is high or during the RECOVER_CYCLES cycles that follow it, even for a complete valid handshake. A valid handshake after that window is honoured.
- R6: With pgm_en_i low, no pulse is produced. If pgm_en_i drops between the two frames, the handshake is abandoned.
- R7: An opening frame with any other 24-bit value, or a commit frame whose value is neither 0x020001 nor 0x020003, abandons the handshake without a pulse.
- R8: A frame with fewer or more than 24 rising serial-clock edges while chip select is low is treated as invalid and abandons the handshake.
- R9: If chip select goes low again after fewer than GAP_CYCLES cycles high between the frames, the handshake is abandoned.
- R10: A commit frame with no accepted opening frame before it produces no pulse. set_trip_o and reset_trip_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock (mode 0, idle low) |
| sdi_i | input | 1 | Serial data into the block |
| csn_i | input | 1 | Active-low chip select |
| pgm_en_i | input | 1 | Program-enable level (programming voltage present) |
| set_trip_o | output | 1 | One-cycle pulse: raise the threshold |
| reset_trip_o | output | 1 | One-cycle pulse: reset the threshold to native level |
| busy_o | output | 1 | High during the write time after a command |

## Verification
Chip select is driven on a falling clock edge. The command pulse is then due in the cycle after the third rising edge with the default two-stage synchronizer, so the bench samples at the second falling edge, where it expects low, and at the third, where it expects high. busy_o is counted on falling edges from that same sample until it drops, and the count must equal WRITE_CYCLES. For the abort cases, the table waits through the write and recovery windows before it compares pulse counters taken from the outputs. A late or missing pulse therefore shows up as a count difference, not as a timing race.

// File: rtl/trip_prog_pkg.sv
package trip_prog_pkg;

  localparam int unsigned FRAME_BITS = 24;

  localparam logic [7:0]  OP_OPEN   = 8'h03;
  localparam logic [7:0]  OP_COMMIT = 8'h02;
  localparam logic [15:0] ARG_RAISE = 16'h0001;
  localparam logic [15:0] ARG_NATIVE = 16'h0003;

  localparam int unsigned LN_SCK   = 0;
  localparam int unsigned LN_SDI   = 1;
  localparam int unsigned LN_CSN   = 2;
  localparam int unsigned LN_EN    = 3;
  localparam int unsigned N_LANES  = 4;

  typedef enum logic [1:0] {
    FK_OPEN,
    FK_RAISE,
    FK_NATIVE,
    FK_BAD
  } frame_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_ARMED,
    ST_WRITE,
    ST_RECOVER
  } seq_state_e;

endpackage

// File: rtl/trip_pin_sync.sv
module trip_pin_sync #(
  parameter int unsigned          STAGES  = 2,
  parameter int unsigned          LANES   = 4,
  parameter logic [LANES-1:0]     RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] pin_i,
  output logic [LANES-1:0] lvl_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{RST_VAL[l]}};
      end else begin
        chain_q[0] <= pin_i[l];
        for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      end
    end

    assign lvl_o[l] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/trip_frame_rx.sv
module trip_frame_rx
  import trip_prog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        sdi_i,
  input  logic        csn_i,
  output logic        cs_fall_o,
  output logic        frame_end_o,
  output frame_kind_e kind_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

  logic                  sck_q, csn_q;
  logic                  sck_rise;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] shift_q;

  assign sck_rise    = sck_i & ~sck_q;
  assign cs_fall_o   = ~csn_i & csn_q;
  assign frame_end_o = csn_i & ~csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      sck_q <= sck_i;
      csn_q <= csn_i;
      if (cs_fall_o) begin
        cnt_q <= '0;
      end else if (sck_rise && !csn_i) begin
        shift_q <= {shift_q[FRAME_BITS-2:0], sdi_i};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;  // saturate: any overrun stays bad
      end
    end
  end

  always_comb begin
    kind_o = FK_BAD;
    if (cnt_q == CNT_FULL) begin
      unique case (shift_q)
        {OP_OPEN,   ARG_RAISE}:  kind_o = FK_OPEN;
        {OP_COMMIT, ARG_RAISE}:  kind_o = FK_RAISE;
        {OP_COMMIT, ARG_NATIVE}: kind_o = FK_NATIVE;
        default:                 kind_o = FK_BAD;
      endcase
    end
  end

endmodule

// File: rtl/trip_wait_timer.sv
module trip_wait_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/trip_seq_fsm.sv
module trip_seq_fsm
  import trip_prog_pkg::*;
#(
  parameter int unsigned GAP_CYCLES     = 125,
  parameter int unsigned WRITE_CYCLES   = 1250000,
  parameter int unsigned RECOVER_CYCLES = 1250000,
  parameter int unsigned TW             = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cs_fall_i,
  input  logic          frame_end_i,
  input  frame_kind_e   kind_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          set_o,
  output logic          reset_o,
  output logic          busy_o
);

  seq_state_e state_q, state_d;
  logic       set_d, reset_d, set_q, reset_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    set_d      = 1'b0;
    reset_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (en_i && frame_end_i && kind_i == FK_OPEN) begin
          state_d    = ST_GAP;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(GAP_CYCLES - 1);
        end
      end
      ST_GAP: begin
        if (!en_i || cs_fall_i) state_d = ST_IDLE;  // gap too short or enable lost
        else if (tmr_zero_i)    state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (!en_i) begin
          state_d = ST_IDLE;
        end else if (frame_end_i) begin
          if (kind_i == FK_RAISE || kind_i == FK_NATIVE) begin
            state_d    = ST_WRITE;
            tmr_load_o = 1'b1;
            tmr_val_o  = TW'(WRITE_CYCLES - 1);
            set_d      = (kind_i == FK_RAISE);
            reset_d    = (kind_i == FK_NATIVE);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (tmr_zero_i) begin
          state_d    = ST_RECOVER;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(RECOVER_CYCLES - 1);
        end
      end
      ST_RECOVER: begin
        if (tmr_zero_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      set_q   <= 1'b0;
      reset_q <= 1'b0;
    end else begin
      state_q <= state_d;
      set_q   <= set_d;
      reset_q <= reset_d;
    end
  end

  assign set_o   = set_q;
  assign reset_o = reset_q;
  assign busy_o  = (state_q == ST_WRITE);

endmodule

// File: rtl/trip_prog_detect.sv
module trip_prog_detect
  import trip_prog_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned GAP_CYCLES     = 125,
  parameter int unsigned WRITE_CYCLES   = 1250000,
  parameter int unsigned RECOVER_CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic csn_i,
  input  logic pgm_en_i,
  output logic set_trip_o,
  output logic reset_trip_o,
  output logic busy_o
);

  localparam int unsigned TMR_MAX0 = (WRITE_CYCLES > RECOVER_CYCLES) ? WRITE_CYCLES : RECOVER_CYCLES;
  localparam int unsigned TMR_MAX  = (TMR_MAX0 > GAP_CYCLES) ? TMR_MAX0 : GAP_CYCLES;
  localparam int unsigned TMR_W    = $clog2(TMR_MAX + 1);
  localparam logic [N_LANES-1:0] LANE_RST = N_LANES'(1) << LN_CSN;

  logic [N_LANES-1:0] pins, lvl;
  logic               en_s;
  logic               cs_fall, frame_end;
  frame_kind_e        kind;
  logic               tmr_load, tmr_zero;
  logic [TMR_W-1:0]   tmr_val;

  always_comb begin
    pins          = '0;
    pins[LN_SCK]  = sck_i;
    pins[LN_SDI]  = sdi_i;
    pins[LN_CSN]  = csn_i;
    pins[LN_EN]   = pgm_en_i;
  end

  trip_pin_sync #(
    .STAGES  (SYNC_STAGES),
    .LANES   (N_LANES),
    .RST_VAL (LANE_RST)
  ) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pins),
    .lvl_o  (lvl)
  );

  assign en_s = lvl[LN_EN];

  trip_frame_rx rx_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_i       (lvl[LN_SCK]),
    .sdi_i       (lvl[LN_SDI]),
    .csn_i       (lvl[LN_CSN]),
    .cs_fall_o   (cs_fall),
    .frame_end_o (frame_end),
    .kind_o      (kind)
  );

  trip_wait_timer #(.WIDTH(TMR_W)) tmr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  trip_seq_fsm #(
    .GAP_CYCLES     (GAP_CYCLES),
    .WRITE_CYCLES   (WRITE_CYCLES),
    .RECOVER_CYCLES (RECOVER_CYCLES),
    .TW             (TMR_W)
  ) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_s),
    .cs_fall_i   (cs_fall),
    .frame_end_i (frame_end),
    .kind_i      (kind),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .set_o       (set_trip_o),
    .reset_o     (reset_trip_o),
    .busy_o      (busy_o)
  );

endmodule

// File: rtl/trip_prog_detect_chk.sv
module trip_prog_detect_chk #(
  parameter int unsigned WRITE_CYCLES   = 1250000,
  parameter int unsigned RECOVER_CYCLES = 1250000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic set_i,
  input logic reset_i,
  input logic busy_i,
  input logic en_s_i
);

  localparam int unsigned BW = $clog2(WRITE_CYCLES + 2);
  localparam int unsigned QW = $clog2(RECOVER_CYCLES + 2);

  logic [BW-1:0] busy_len_q;
  logic [QW-1:0] quiet_q;
  logic          busy_q;
  logic          fire;

  assign fire = set_i | reset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_len_q <= '0;
      quiet_q    <= '0;
      busy_q     <= 1'b0;
    end else begin
      busy_q     <= busy_i;
      busy_len_q <= busy_i ? busy_len_q + 1'b1 : '0;
      if (busy_q && !busy_i)                                  quiet_q <= QW'(1);
      else if (quiet_q != '0 && quiet_q < QW'(RECOVER_CYCLES)) quiet_q <= quiet_q + 1'b1;
      else                                                     quiet_q <= '0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !fire);  // R2

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_i, reset_i}));  // R10

  AST_PULSE_OPENS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> busy_i);  // R4

  AST_BUSY_NEEDS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> fire);  // R4

  AST_BUSY_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (busy_len_q == BW'(WRITE_CYCLES)));  // R4

  AST_QUIET_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> (quiet_q == '0 && !busy_q));  // R5

  AST_FIRE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> $past(en_s_i));  // R6

endmodule

bind trip_prog_detect trip_prog_detect_chk #(
  .WRITE_CYCLES   (WRITE_CYCLES),
  .RECOVER_CYCLES (RECOVER_CYCLES)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .set_i   (set_trip_o),
  .reset_i (reset_trip_o),
  .busy_i  (busy_o),
  .en_s_i  (en_s)
);

// File: tb/trip_prog_detect_tb_top.sv
module trip_prog_detect_tb_top;

  localparam int unsigned SYNC = 2;
  localparam int unsigned GAP  = 16;
  localparam int unsigned WR   = 200;
  localparam int unsigned RC   = 300;
  localparam int          NVEC = 11;

  typedef struct packed {
    logic [31:0] f1;
    logic [5:0]  n1;
    logic [7:0]  gap;
    logic [31:0] f2;
    logic [5:0]  n2;
    logic [1:0]  en;     // 0 off, 1 on, 2 dropped between frames
    logic        exp_set;
    logic        exp_rst;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h030001, 6'd24, 8'd40, 32'h020001, 6'd24, 2'd1, 1'b1, 1'b0, 4'd2},  // R2 raise
    '{32'h030001, 6'd24, 8'd40, 32'h020003, 6'd24, 2'd1, 1'b0, 1'b1, 4'd3},  // R3 native
    '{32'h030001, 6'd24, 8'd40, 32'h020001, 6'd24, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 enable off
    '{32'h030001, 6'd24, 8'd40, 32'h020001, 6'd24, 2'd2, 1'b0, 1'b0, 4'd6},  // R6 enable dropped
    '{32'h040001, 6'd24, 8'd40, 32'h020001, 6'd24, 2'd1, 1'b0, 1'b0, 4'd7},  // R7 bad opener
    '{32'h030001, 6'd24, 8'd40, 32'h020002, 6'd24, 2'd1, 1'b0, 1'b0, 4'd7},  // R7 bad commit
    '{32'h018000, 6'd23, 8'd40, 32'h020001, 6'd24, 2'd1, 1'b0, 1'b0, 4'd8},  // R8 short opener
    '{32'h030001, 6'd24, 8'd40, 32'h020001, 6'd25, 2'd1, 1'b0, 1'b0, 4'd8},  // R8 long commit
    '{32'h030001, 6'd24, 8'd3,  32'h020001, 6'd24, 2'd1, 1'b0, 1'b0, 4'd9},  // R9 short gap
    '{32'h020001, 6'd24, 8'd40, 32'h020001, 6'd24, 2'd1, 1'b0, 1'b0, 4'd10}, // R10 no opener
    '{32'h030001, 6'd24, 8'd40, 32'h020003, 6'd24, 2'd1, 1'b0, 1'b1, 4'd3}   // R3 again
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, csn = 1'b1, pgm_en = 1'b0;
  logic set_trip, reset_trip, busy;

  int n_checks = 0, n_err = 0;
  int set_cnt = 0, rst_cnt = 0, both_cnt = 0;

  always #4 clk = ~clk;

  trip_prog_detect #(
    .SYNC_STAGES    (SYNC),
    .GAP_CYCLES     (GAP),
    .WRITE_CYCLES   (WR),
    .RECOVER_CYCLES (RC)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sck_i        (sck),
    .sdi_i        (sdi),
    .csn_i        (csn),
    .pgm_en_i     (pgm_en),
    .set_trip_o   (set_trip),
    .reset_trip_o (reset_trip),
    .busy_o       (busy)
  );

  always @(negedge clk) begin
    if (set_trip)              set_cnt++;
    if (reset_trip)            rst_cnt++;
    if (set_trip && reset_trip) both_cnt++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_frame(logic [31:0] val, int nbits);
    csn = 1'b0;
    tick(4);
    for (int b = nbits - 1; b >= 0; b--) begin
      sdi = val[b];
      tick(4);
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
    tick(4);
    csn = 1'b1;
  endtask

  task automatic send_seq(logic [31:0] f1, int n1, int gap, logic [31:0] f2, int n2, int mode);
    pgm_en = (mode != 0);
    tick(8);
    send_frame(f1, n1);
    if (mode == 2) begin
      tick(2);
      pgm_en = 1'b0;
      tick(8);
      pgm_en = 1'b1;
    end
    tick(gap);
    send_frame(f2, n2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    int s0, r0, n;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1", "set after reset", int'(set_trip), 0);
    check("R1", "reset after reset", int'(reset_trip), 0);
    check("R1", "busy after reset", int'(busy), 0);

    // R2 exact pulse timing, R4 busy width
    send_seq(32'h030001, 24, 40, 32'h020001, 24, 1);
    tick(2);
    check("R2", "set before due edge", int'(set_trip), 0);
    tick(1);
    check("R2", "set on due edge", int'(set_trip), 1);
    check("R4", "busy with pulse", int'(busy), 1);
    n = 0;
    while (busy) begin
      n++;
      tick(1);
    end
    check("R4", "busy width", n, WR);
    check("R2", "set pulse count", set_cnt, 1);
    tick(RC + 40);

    // R5 handshake during write/recovery is ignored, then honoured
    send_seq(32'h030001, 24, 40, 32'h020003, 24, 1);
    tick(3);
    check("R3", "native pulse", int'(reset_trip), 1);
    s0 = set_cnt;
    send_seq(32'h030001, 24, 40, 32'h020001, 24, 1);
    tick(WR + RC);
    check("R5", "no pulse inside window", set_cnt - s0, 0);
    send_seq(32'h030001, 24, 40, 32'h020001, 24, 1);
    tick(WR + RC + 60);
    check("R5", "pulse after window", set_cnt - s0, 1);

    // table of handshakes
    for (int i = 0; i < NVEC; i++) begin
      s0 = set_cnt;
      r0 = rst_cnt;
      send_seq(VECS[i].f1, int'(VECS[i].n1), int'(VECS[i].gap),
               VECS[i].f2, int'(VECS[i].n2), int'(VECS[i].en));
      tick(WR + RC + 60);
      if (set_cnt - s0 != int'(VECS[i].exp_set) || rst_cnt - r0 != int'(VECS[i].exp_rst))
        $display("vector %0d mismatch (R%0d)", i, VECS[i].req);
      check("table", "set pulses", set_cnt - s0, int'(VECS[i].exp_set));
      check("table", "native pulses", rst_cnt - r0, int'(VECS[i].exp_rst));
    end

    // R10 exclusivity over whole run
    check("R10", "both pulses together", both_cnt, 0);
    check("R4", "busy idle at end", int'(busy), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule